// File: doc/BRIEF.md
# Vector Branch Condition Evaluator

This block decides a vectorised conditional branch. A start strobe loads a vector length, one condition bit and one predicate bit per element, a 64-bit loop counter and a set of mode controls. The block then walks the elements one per clock. Each element's condition bit is compared against a requested sense. The predicate and a zeroing control decide whether a masked-out element is skipped or is tested as a zero. The per-element outcomes fold into one taken or not-taken decision. Under the all-pass rule every tested element must match. Under the any-pass rule one match is enough.

Two side effects can be switched on, and they turn the test into a loop-control step. In counter mode the loop counter drops by one for each tested element, or with inversion only for each failing one. In length-truncation mode the vector length is cut back to end at the element that settled the outcome. The cut happens when the outcome matches the sense bit. The controller has three named states. IDLE waits for start: it goes to EVAL on a non-empty vector, or directly to DONE on an empty one. EVAL tests one element per cycle and goes to DONE on a deciding element or on the last one. DONE raises the done flag for one cycle and always returns to IDLE. Target addresses and link writes are handled elsewhere.

Top module: `vec_branch_eval`

## Requirements
- R1: `mode[1]` enables counter mode and `mode[0]` enables length truncation; the codes are 00 = plain test, 01 = truncation only, 10 = counter only, 11 = both. With `mode[1]`=0 the result `ctr_out` equals `ctr_in`. With `mode[0]`=0 the result `vl_out` equals the loaded length.
- R2: With `zero_en`=0, an element whose predicate bit is 0 is not tested, cannot decide the outcome and never changes the counter, although it still takes one clock.
- R3: With `zero_en`=1, an element whose predicate bit is 0 is tested with a 0 in place of its condition bit.
- R4: An element passes when its tested bit equals `sense`. With `all_mode`=1 the branch is taken only if no tested element fails. With `all_mode`=0 it is taken if at least one tested element passes.
- R5: Evaluation stops at the first deciding element, meaning the first failure under `all_mode`=1 or the first pass under `all_mode`=0. `done` rises N+1 clock edges after the accepting edge, where N is the deciding index plus one, or the loaded length if no element decides.
- R6: In counter mode the counter drops by one for each tested element among those evaluated, and wraps modulo 2^64.
- R7: With `ctr_inv`=1 in counter mode, only tested elements that fail decrement the counter.
- R8: In truncation mode the length is cut when the branch is taken with `sense`=1, or not taken with `sense`=0. A cut length equals the deciding index plus one. When no element decides, the length is unchanged.
- R9: A loaded length of 0 tests nothing: `ctr_out`=`ctr_in`, `vl_out`=0, and `taken`=`all_mode`. `done` rises one edge after acceptance. A length above MAX_VL is treated as MAX_VL.
- R10: `done` is high for exactly one cycle. `start` is ignored unless the block is idle.
- R11: After reset, `done`, `taken`, `ctr_out` and `vl_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load operands and begin evaluation (taken only in IDLE) |
| vl_in | input | VW | Vector length, clamped to MAX_VL |
| cond_in | input | MAX_VL | Condition bit per element, bit i = element i |
| pred_in | input | MAX_VL | Predicate bit per element, bit i = element i |
| ctr_in | input | CTR_W | Loop counter before the operation |
| mode | input | 2 | Bit 1 counter mode, bit 0 length truncation |
| all_mode | input | 1 | 1 = all tested must pass, 0 = any pass suffices |
| sense | input | 1 | Required value of the tested bit |
| zero_en | input | 1 | 1 = masked elements are tested as zero |
| ctr_inv | input | 1 | 1 = decrement only on failing elements |
| taken | output | 1 | Branch decision, valid while done is high |
| ctr_out | output | CTR_W | Updated loop counter, valid while done is high |
| vl_out | output | VW | Updated vector length, valid while done is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
All results appear together with `done`. `done` comes N+1 rising edges after the edge that accepted `start`, where N is the number of elements walked, so an empty vector finishes after one edge. The bench drives on falling edges and counts falling edges from the accepting edge until `done`. It compares that count with the N from its own model and reads `taken`, `ctr_out` and `vl_out` in that same half-cycle. The cycle after `done` is sampled as well, to confirm the pulse lasts only one cycle.

// File: rtl/vbe_pkg.sv
package vbe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_DONE = 2'd2
    } vbe_state_e;

    typedef struct packed {
        logic ctr_en;
        logic vlt_en;
        logic all_mode;
        logic sense;
        logic zero_en;
        logic ctr_inv;
    } vbe_ctl_t;
endpackage

// File: rtl/vbe_elem_test.sv
// Tests one element: applies predicate/zeroing and reports pass and decisiveness.
module vbe_elem_test (
    input  logic cond_bit,
    input  logic pred_bit,
    input  logic zero_en,
    input  logic sense,
    input  logic all_mode,
    output logic tested,
    output logic pass,
    output logic decisive
);
    logic eff_bit;

    always_comb begin
        tested   = pred_bit | zero_en;
        eff_bit  = pred_bit & cond_bit;
        pass     = (eff_bit == sense);
        decisive = tested & (all_mode ? ~pass : pass);
    end
endmodule

// File: rtl/vbe_ctr_step.sv
// Conditional single decrement of the loop counter.
module vbe_ctr_step #(
    parameter int CTR_W = 64
) (
    input  logic             ctr_en,
    input  logic             ctr_inv,
    input  logic             tested,
    input  logic             pass,
    input  logic [CTR_W-1:0] ctr_cur,
    output logic [CTR_W-1:0] ctr_nxt
);
    logic dec;

    always_comb begin
        dec     = ctr_en & tested & (~ctr_inv | ~pass);
        ctr_nxt = dec ? (ctr_cur - CTR_W'(1)) : ctr_cur;
    end
endmodule

// File: rtl/vbe_vl_trunc.sv
// Chooses the final vector length from the outcome and the deciding element.
module vbe_vl_trunc #(
    parameter int VW = 4
) (
    input  logic          vlt_en,
    input  logic          sense,
    input  logic          taken,
    input  logic          decided,
    input  logic [VW-1:0] idx,
    input  logic [VW-1:0] vl_cur,
    output logic [VW-1:0] vl_new
);
    logic cut;

    always_comb begin
        cut    = vlt_en & decided & (sense ? taken : ~taken);
        vl_new = cut ? (idx + VW'(1)) : vl_cur;
    end
endmodule

// File: rtl/vec_branch_eval.sv
module vec_branch_eval
    import vbe_pkg::*;
#(
    parameter int MAX_VL = 8,
    parameter int CTR_W  = 64,
    localparam int VW    = $clog2(MAX_VL + 1),
    localparam int IW    = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [VW-1:0]     vl_in,
    input  logic [MAX_VL-1:0] cond_in,
    input  logic [MAX_VL-1:0] pred_in,
    input  logic [CTR_W-1:0]  ctr_in,
    input  logic [1:0]        mode,
    input  logic              all_mode,
    input  logic              sense,
    input  logic              zero_en,
    input  logic              ctr_inv,
    output logic              taken,
    output logic [CTR_W-1:0]  ctr_out,
    output logic [VW-1:0]     vl_out,
    output logic              done
);
    localparam logic [VW-1:0] VL_LIMIT = VW'(MAX_VL);

    vbe_state_e        state_q, state_d;
    vbe_ctl_t          ctl_q;
    logic [MAX_VL-1:0] cond_q, pred_q;
    logic [VW-1:0]     vl_q, idx_q, vl_res_q;
    logic [CTR_W-1:0]  ctr_q;
    logic              taken_q;

    logic [VW-1:0]     vl_clamped;
    logic [IW-1:0]     sel;
    logic              e_tested, e_pass, e_decisive;
    logic              is_last, finish, taken_now;
    logic [CTR_W-1:0]  ctr_nxt;
    logic [VW-1:0]     vl_new;

    assign vl_clamped = (vl_in > VL_LIMIT) ? VL_LIMIT : vl_in;
    assign sel        = idx_q[IW-1:0];
    assign is_last    = (idx_q == (vl_q - VW'(1)));
    assign finish     = e_decisive | is_last;
    assign taken_now  = e_decisive ? ~ctl_q.all_mode : ctl_q.all_mode;

    vbe_elem_test u_elem (
        .cond_bit (cond_q[sel]),
        .pred_bit (pred_q[sel]),
        .zero_en  (ctl_q.zero_en),
        .sense    (ctl_q.sense),
        .all_mode (ctl_q.all_mode),
        .tested   (e_tested),
        .pass     (e_pass),
        .decisive (e_decisive)
    );

    vbe_ctr_step #(.CTR_W(CTR_W)) u_ctr (
        .ctr_en  (ctl_q.ctr_en),
        .ctr_inv (ctl_q.ctr_inv),
        .tested  (e_tested),
        .pass    (e_pass),
        .ctr_cur (ctr_q),
        .ctr_nxt (ctr_nxt)
    );

    vbe_vl_trunc #(.VW(VW)) u_trunc (
        .vlt_en  (ctl_q.vlt_en),
        .sense   (ctl_q.sense),
        .taken   (taken_now),
        .decided (e_decisive),
        .idx     (idx_q),
        .vl_cur  (vl_q),
        .vl_new  (vl_new)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: IDLE->EVAL (start, length>0), IDLE->DONE (start, length 0),
    // EVAL->DONE (deciding or last element), DONE->IDLE (always)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (vl_clamped == '0) ? ST_DONE : ST_EVAL;
            ST_EVAL: if (finish) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Operand capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            cond_q   <= '0;
            pred_q   <= '0;
            vl_q     <= '0;
            idx_q    <= '0;
            ctr_q    <= '0;
            vl_res_q <= '0;
            taken_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    ctl_q    <= '{ctr_en: mode[1], vlt_en: mode[0], all_mode: all_mode,
                                  sense: sense, zero_en: zero_en, ctr_inv: ctr_inv};
                    cond_q   <= cond_in;
                    pred_q   <= pred_in;
                    vl_q     <= vl_clamped;
                    idx_q    <= '0;
                    ctr_q    <= ctr_in;
                    vl_res_q <= vl_clamped;
                    taken_q  <= all_mode;
                end
                ST_EVAL: begin
                    ctr_q <= ctr_nxt;
                    idx_q <= idx_q + VW'(1);
                    if (finish) begin
                        taken_q  <= taken_now;
                        vl_res_q <= vl_new;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign done    = (state_q == ST_DONE);
    assign taken   = taken_q;
    assign ctr_out = ctr_q;
    assign vl_out  = vl_res_q;
endmodule

// File: rtl/vbe_checker.sv
module vbe_checker #(
    parameter int MAX_VL = 8,
    parameter int CTR_W  = 64,
    localparam int VW    = $clog2(MAX_VL + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [VW-1:0]     vl_in,
    input logic [CTR_W-1:0]  ctr_in,
    input logic [1:0]        mode,
    input logic              all_mode,
    input logic              taken,
    input logic [CTR_W-1:0]  ctr_out,
    input logic [VW-1:0]     vl_out,
    input logic              done
);
    logic             busy;
    logic [VW-1:0]    vl_cap;
    logic [CTR_W-1:0] ctr_cap;
    logic [1:0]       mode_cap;
    logic             all_cap;
    logic [VW:0]      lat_cnt;
    logic             accept;

    assign accept = start & ~busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy <= 1'b0; vl_cap <= '0; ctr_cap <= '0;
            mode_cap <= '0; all_cap <= 1'b0; lat_cnt <= '0;
        end else if (accept) begin
            busy     <= 1'b1;
            vl_cap   <= (vl_in > VW'(MAX_VL)) ? VW'(MAX_VL) : vl_in;
            ctr_cap  <= ctr_in;
            mode_cap <= mode;
            all_cap  <= all_mode;
            lat_cnt  <= '0;
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_needs_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    assert_ctr_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_cap[1]) |-> (ctr_out == ctr_cap));
    assert_vl_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_cap[0]) |-> (vl_out == vl_cap));
    assert_vl_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vl_out <= vl_cap));
    assert_ctr_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((ctr_cap - ctr_out) <= {{(CTR_W-VW){1'b0}}, vl_cap}));
    assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt <= {1'b0, vl_cap}));
    assert_empty_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && vl_cap == '0) |-> (taken == all_cap && ctr_out == ctr_cap && vl_out == '0));
endmodule

bind vec_branch_eval vbe_checker #(.MAX_VL(MAX_VL), .CTR_W(CTR_W)) u_vbe_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .vl_in    (vl_in),
    .ctr_in   (ctr_in),
    .mode     (mode),
    .all_mode (all_mode),
    .taken    (taken),
    .ctr_out  (ctr_out),
    .vl_out   (vl_out),
    .done     (done)
);

// File: tb/vec_branch_eval_bench.sv
module vec_branch_eval_bench;
    localparam int MAX_VL = 8;
    localparam int CTR_W  = 64;
    localparam int VW     = $clog2(MAX_VL + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [VW-1:0]     vl_in = '0;
    logic [MAX_VL-1:0] cond_in = '0, pred_in = '0;
    logic [CTR_W-1:0]  ctr_in = '0;
    logic [1:0]        mode = '0;
    logic              all_mode = 0, sense = 0, zero_en = 0, ctr_inv = 0;
    logic              taken, done;
    logic [CTR_W-1:0]  ctr_out;
    logic [VW-1:0]     vl_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    vec_branch_eval #(.MAX_VL(MAX_VL), .CTR_W(CTR_W)) u_vec_branch_eval (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
        .cond_in(cond_in), .pred_in(pred_in), .ctr_in(ctr_in), .mode(mode),
        .all_mode(all_mode), .sense(sense), .zero_en(zero_en), .ctr_inv(ctr_inv),
        .taken(taken), .ctr_out(ctr_out), .vl_out(vl_out), .done(done)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [CTR_W-1:0] got, input logic [CTR_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // Independent model of the requirements
    task automatic model(input int vl, input logic [MAX_VL-1:0] c, input logic [MAX_VL-1:0] p,
                         input logic [1:0] md, input logic al, input logic sn, input logic ze,
                         input logic inv, input logic [CTR_W-1:0] ci,
                         output logic e_taken, output logic [CTR_W-1:0] e_ctr,
                         output int e_vl, output int e_lat);
        bit stop = 0;
        int at = 0;
        int v = (vl > MAX_VL) ? MAX_VL : vl;
        e_ctr = ci;
        for (int i = 0; i < v; i++) begin
            if (!stop && (p[i] || ze)) begin
                logic b = p[i] ? c[i] : 1'b0;
                logic ok = (b == sn);
                if (md[1] && (!inv || !ok)) e_ctr = e_ctr - 1;
                if (al ? !ok : ok) begin stop = 1; at = i; end
            end
        end
        e_taken = stop ? !al : al;
        e_lat   = (stop ? at + 1 : v) + 1;
        e_vl    = (md[0] && stop && (sn ? e_taken : !e_taken)) ? at + 1 : v;
    endtask

    task automatic run(input int vl, input logic [MAX_VL-1:0] c, input logic [MAX_VL-1:0] p,
                       input logic [1:0] md, input logic al, input logic sn, input logic ze,
                       input logic inv, input logic [CTR_W-1:0] ci,
                       output logic g_taken, output logic [CTR_W-1:0] g_ctr,
                       output int g_vl, output int g_lat, output logic g_after);
        @(negedge clk);
        vl_in = VW'(vl); cond_in = c; pred_in = p; mode = md; all_mode = al;
        sense = sn; zero_en = ze; ctr_inv = inv; ctr_in = ci; start = 1;
        @(negedge clk);
        start = 0;
        g_lat = 1;
        while (!done && g_lat < 40) begin
            @(negedge clk);
            g_lat++;
        end
        g_taken = taken; g_ctr = ctr_out; g_vl = int'(vl_out);
        @(negedge clk);
        g_after = done;
    endtask

    task automatic run_check(input string tag, input int vl, input logic [MAX_VL-1:0] c,
                             input logic [MAX_VL-1:0] p, input logic [1:0] md, input logic al,
                             input logic sn, input logic ze, input logic inv,
                             input logic [CTR_W-1:0] ci);
        logic et, gt, ga;
        logic [CTR_W-1:0] ec, gc;
        int ev, el, gv, gl;
        model(vl, c, p, md, al, sn, ze, inv, ci, et, ec, ev, el);
        run(vl, c, p, md, al, sn, ze, inv, ci, gt, gc, gv, gl, ga);
        check({tag, " taken R4"}, CTR_W'(gt), CTR_W'(et));
        check({tag, " ctr R6"}, gc, ec);
        check({tag, " vl R8"}, CTR_W'(gv), CTR_W'(ev));
        check({tag, " latency R5"}, CTR_W'(gl), CTR_W'(el));
        check({tag, " pulse R10"}, CTR_W'(ga), '0);
    endtask

    initial begin
        logic gt, ga;
        logic [CTR_W-1:0] gc;
        int gv, gl;
        repeat (3) @(negedge clk);
        // R11: reset values
        check("reset done R11", CTR_W'(done), 0);
        check("reset taken R11", CTR_W'(taken), 0);
        check("reset ctr R11", ctr_out, 0);
        check("reset vl R11", CTR_W'(vl_out), 0);
        rst_n = 1;

        // R1: mode 00 leaves counter and length alone even when an element decides
        run(8, 8'h01, 8'hFF, 2'b00, 0, 1, 0, 0, 64'd100, gt, gc, gv, gl, ga);
        check("mode00 ctr R1", gc, 64'd100);
        check("mode00 vl R1", CTR_W'(gv), 8);
        check("mode00 taken R4", CTR_W'(gt), 1);

        // R2: all masked out, no zeroing -> nothing tested, full walk
        run(4, 8'hFF, 8'h00, 2'b11, 0, 1, 0, 0, 64'd50, gt, gc, gv, gl, ga);
        check("skip ctr R2", gc, 64'd50);
        check("skip taken R2", CTR_W'(gt), 0);
        check("skip latency R2", CTR_W'(gl), 5);

        // R3: masked element with zeroing tests a 0 against sense 1 -> fails, decides under ALL
        run(8, 8'hFF, 8'hFE, 2'b11, 1, 1, 1, 1, 64'd9, gt, gc, gv, gl, ga);
        check("zero taken R3", CTR_W'(gt), 0);
        check("zero ctr R3", gc, 64'd8);
        check("zero vl R3", CTR_W'(gv), 8);
        check("zero latency R3", CTR_W'(gl), 2);

        // R7: inversion counts four failures before the pass at element 4; truncation to 5
        run(8, 8'h10, 8'hFF, 2'b11, 0, 1, 0, 1, 64'd20, gt, gc, gv, gl, ga);
        check("inv ctr R7", gc, 64'd16);
        check("inv vl R8", CTR_W'(gv), 5);
        check("inv taken R4", CTR_W'(gt), 1);

        // R6: counter wraps below zero
        run(3, 8'h07, 8'hFF, 2'b10, 1, 1, 0, 0, 64'd0, gt, gc, gv, gl, ga);
        check("wrap ctr R6", gc, 64'hFFFF_FFFF_FFFF_FFFD);

        // R9: empty vector and oversize length
        run(0, 8'h00, 8'hFF, 2'b11, 1, 1, 0, 0, 64'd7, gt, gc, gv, gl, ga);
        check("empty taken R9", CTR_W'(gt), 1);
        check("empty ctr R9", gc, 64'd7);
        check("empty latency R9", CTR_W'(gl), 1);
        run_check("oversize R9", 15, 8'hFF, 8'hFF, 2'b10, 1, 1, 0, 0, 64'd30);

        // R10: start during EVAL is ignored
        @(negedge clk);
        vl_in = 4'd6; cond_in = 8'h3F; pred_in = 8'hFF; mode = 2'b10; all_mode = 1;
        sense = 1; zero_en = 0; ctr_inv = 0; ctr_in = 64'd40; start = 1;
        @(negedge clk);
        vl_in = 4'd2; ctr_in = 64'd999; start = 1;
        @(negedge clk);
        start = 0;
        gl = 2;
        while (!done && gl < 40) begin @(negedge clk); gl++; end
        check("busy start ctr R10", ctr_out, 64'd34);
        check("busy start latency R10", CTR_W'(gl), 7);
        @(negedge clk);
        check("busy start pulse R10", CTR_W'(done), 0);

        // Near-exhaustive sweep over controls, lengths and patterns (R1..R9)
        for (int ctl = 0; ctl < 64; ctl++) begin
            for (int vl = 0; vl <= MAX_VL; vl++) begin
                for (int pt = 0; pt < 5; pt++) begin
                    logic [MAX_VL-1:0] c = MAX_VL'((pt * 91 + vl * 37 + ctl * 13) ^ 8'hA5);
                    logic [MAX_VL-1:0] p = (pt == 0) ? '1 : MAX_VL'((pt * 53 + ctl * 7) ^ 8'h3C);
                    run_check("sweep", vl, c, p, 2'(ctl), ctl[2], ctl[3], ctl[4], ctl[5],
                              64'd1000 + 64'(ctl));
                end
            end
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule